// File: doc/BRIEF.md
# Asynchronous Cache-Line Undo Logger

This block sits beside a host agent that asks for exclusive ownership of cache lines before it modifies them. Ownership is granted in the same cycle as the request. The crash-consistency work happens afterwards, in the background. For the first modification of a line in an epoch, the block queues the line address and then reads the line's prior contents from persistent memory. It appends a record to a circular undo log. The record carries the address, the old contents and the epoch tag. A line that was already logged in the current epoch is granted again and produces no new record.

A durable offset counts the log records the log memory has acknowledged. It only moves forward, one record at a time, in append order. Write-back logic uses it to decide when a modified line may go back to persistent memory. An epoch input marks commit points. When its value changes, the set of lines already logged is emptied. An iterator port then lets a commit sequencer replay the line addresses logged since that change, oldest first.

Top module: `undo_logger`

## Requirements
- R1: A request for a line that is not yet logged, with space in both the pending queue and the logged-line set, is granted through `req_grant` in the same cycle as `req_valid`, with no dependence on memory or log activity.
- R2: The first granted request for an address within an epoch produces exactly one log record. Later requests for the same address in that epoch are granted and produce no record.
- R3: Four new-line requests waiting in the pending queue make the queue full. While the queue is full, a request for an address that is not logged is refused (`req_grant` low). A request for an already-logged address is still granted.
- R4: Each log record carries the granted line address, the data returned by the memory read of that address, and the epoch value that was in effect when the request was granted.
- R5: `durable_off` is 0 after reset. It grows by exactly one for each log write acknowledged by `log_wr_ack`, and records are written in grant order. It does not move while an acknowledgement is withheld.
- R6: The log slot of each record equals `durable_off` modulo LOG_DEPTH (16 by default) at the time of the write, so the log wraps around.
- R7: A request is refused in any cycle where `epoch_in` differs from the epoch held by the block. After the epoch changes, an address logged in an earlier epoch is logged again, tagged with the new epoch.
- R8: Eight distinct lines logged in one epoch fill the logged-line set. Once it is full, a request for another new line is refused, while a request for a logged line is still granted.
- R9: The iterator returns the addresses of the records appended since the last epoch change, in append order. `iter_rewind` sets the cursor back to the first of these records, and `iter_next` advances it one record. `iter_valid` goes low when the cursor reaches `durable_off`.
- R10: After reset, `req_grant`, `mem_rd_req`, `log_wr_req` and `iter_valid` are low.
- R11: Only one memory operation is outstanding at a time. `mem_rd_req` and `log_wr_req` are never high together. Each request is held, with stable address and data, until its response arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Ownership request present |
| req_addr | input | ADDR_W | Line address of the request |
| req_grant | output | 1 | Same-cycle grant of exclusive ownership |
| epoch_in | input | EPOCH_W | Current epoch number; a new value starts a new epoch |
| mem_rd_req | output | 1 | Read request to persistent memory, held until data returns |
| mem_rd_addr | output | ADDR_W | Line address to read |
| mem_rd_valid | input | 1 | Read data valid |
| mem_rd_data | input | DATA_W | Prior line contents |
| log_wr_req | output | 1 | Log append request, held until acknowledged |
| log_wr_slot | output | SLOT_W | Circular log slot being written |
| log_wr_addr | output | ADDR_W | Record: line address |
| log_wr_data | output | DATA_W | Record: old line contents |
| log_wr_epoch | output | EPOCH_W | Record: epoch tag |
| log_wr_ack | input | 1 | Log write is durable |
| durable_off | output | OFF_W | Count of durable records |
| iter_rewind | input | 1 | Move the replay cursor back to the epoch start |
| iter_next | input | 1 | Advance the replay cursor |
| iter_valid | output | 1 | Cursor points at a durable record of this epoch |
| iter_addr | output | ADDR_W | Line address at the cursor |

## Verification
The checker watches several rules on every cycle. It confirms that a full queue only ever grants lines that are already logged. It confirms that no request is granted while the epoch is changing. It confirms that the durable offset moves only by one, and only after an acknowledged log write. Finally, it checks that the read and append requests never overlap and hold steady until answered. Other behaviours only show through the bench's scenarios:
- that repeat requests write no record;
- the record contents and epoch tags;
- the order in which the iterator replays addresses;
- that the log slot wraps around;
- that an address is logged again after an epoch change.

// File: rtl/undo_logger_pkg.sv
package undo_logger_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2
  } lg_state_e;
endpackage

// File: rtl/ul_pend_fifo.sv
module ul_pend_fifo #(
  parameter int W     = 24,
  parameter int DEPTH = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [W-1:0]     din,
  input  logic             pop,
  output logic [W-1:0]     dout,
  output logic             empty,
  output logic             full,
  output logic [CNT_W-1:0] count
);
  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] cnt;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty = (cnt == '0);
  assign full  = (cnt == CNT_W'(DEPTH));
  assign count = cnt;
  assign dout  = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push && !full) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (push && !full) wr_ptr <= bump(wr_ptr);
      if (pop && !empty) rd_ptr <= bump(rd_ptr);
      case ({push && !full, pop && !empty})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/ul_line_set.sv
module ul_line_set #(
  parameter int ADDR_W = 16,
  parameter int N      = 8,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic [ADDR_W-1:0] look_addr,
  output logic              hit,
  output logic              full,
  input  logic              ins
);
  logic [N-1:0]      vld;
  logic [ADDR_W-1:0] tag [N];
  logic [N-1:0]      match;
  logic [IDX_W-1:0]  free_idx;

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign match[g] = vld[g] && (tag[g] == look_addr);
  end

  assign hit  = |match;
  assign full = &vld;

  always_comb begin
    free_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!vld[i]) free_idx = IDX_W'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (ins && !full) tag[free_idx] <= look_addr;
  end

  always_ff @(posedge clk) begin
    if (rst || clear) vld <= '0;
    else if (ins && !full) vld[free_idx] <= 1'b1;
  end
endmodule

// File: rtl/ul_iter.sv
module ul_iter #(
  parameter int ADDR_W    = 16,
  parameter int LOG_DEPTH = 16,
  parameter int OFF_W     = 16,
  localparam int SLOT_W   = $clog2(LOG_DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [SLOT_W-1:0] wr_slot,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [OFF_W-1:0]  durable,
  input  logic              mark,
  input  logic              rewind,
  input  logic              step,
  output logic              valid,
  output logic [ADDR_W-1:0] addr
);
  logic [ADDR_W-1:0] ring [LOG_DEPTH];
  logic [OFF_W-1:0]  base, cursor;

  assign valid = (cursor != durable);
  assign addr  = ring[cursor[SLOT_W-1:0]];

  always_ff @(posedge clk) begin
    if (wr_en) ring[wr_slot] <= wr_addr;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      base   <= '0;
      cursor <= '0;
    end else if (mark) begin
      base   <= durable;
      cursor <= durable;
    end else if (rewind) begin
      cursor <= base;
    end else if (step && valid) begin
      cursor <= cursor + 1'b1;
    end
  end
endmodule

// File: rtl/undo_logger.sv
module undo_logger
  import undo_logger_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 32,
  parameter int EPOCH_W   = 8,
  parameter int OFF_W     = 16,
  parameter int QDEPTH    = 4,
  parameter int SET_N     = 8,
  parameter int LOG_DEPTH = 16,
  localparam int SLOT_W   = $clog2(LOG_DEPTH),
  localparam int QCNT_W   = $clog2(QDEPTH + 1),
  localparam int ENT_W    = ADDR_W + EPOCH_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  input  logic [ADDR_W-1:0]  req_addr,
  output logic               req_grant,
  input  logic [EPOCH_W-1:0] epoch_in,
  output logic               mem_rd_req,
  output logic [ADDR_W-1:0]  mem_rd_addr,
  input  logic               mem_rd_valid,
  input  logic [DATA_W-1:0]  mem_rd_data,
  output logic               log_wr_req,
  output logic [SLOT_W-1:0]  log_wr_slot,
  output logic [ADDR_W-1:0]  log_wr_addr,
  output logic [DATA_W-1:0]  log_wr_data,
  output logic [EPOCH_W-1:0] log_wr_epoch,
  input  logic               log_wr_ack,
  output logic [OFF_W-1:0]   durable_off,
  input  logic               iter_rewind,
  input  logic               iter_next,
  output logic               iter_valid,
  output logic [ADDR_W-1:0]  iter_addr
);
  lg_state_e          state;
  logic [EPOCH_W-1:0] epoch_q;
  logic               epoch_chg;
  logic               set_hit, set_full;
  logic               q_full, q_empty, q_pop, accept_new;
  logic [QCNT_W-1:0]  q_count;
  logic [ENT_W-1:0]   q_out;
  logic [ADDR_W-1:0]  cur_addr;
  logic [EPOCH_W-1:0] cur_epoch;
  logic [DATA_W-1:0]  cur_data;
  logic [OFF_W-1:0]   durable_q;
  logic               wr_done;

  assign epoch_chg  = (epoch_in != epoch_q);
  assign req_grant  = req_valid && !epoch_chg && (set_hit || (!q_full && !set_full));
  assign accept_new = req_grant && !set_hit;
  assign q_pop      = (state == ST_IDLE) && !q_empty;
  assign wr_done    = (state == ST_WRITE) && log_wr_ack;

  ul_line_set #(.ADDR_W(ADDR_W), .N(SET_N)) u_set (
    .clk(clk), .rst(rst), .clear(epoch_chg), .look_addr(req_addr),
    .hit(set_hit), .full(set_full), .ins(accept_new)
  );

  ul_pend_fifo #(.W(ENT_W), .DEPTH(QDEPTH)) u_fifo (
    .clk(clk), .rst(rst), .push(accept_new), .din({req_addr, epoch_q}),
    .pop(q_pop), .dout(q_out), .empty(q_empty), .full(q_full), .count(q_count)
  );

  ul_iter #(.ADDR_W(ADDR_W), .LOG_DEPTH(LOG_DEPTH), .OFF_W(OFF_W)) u_iter (
    .clk(clk), .rst(rst), .wr_en(wr_done), .wr_slot(durable_q[SLOT_W-1:0]),
    .wr_addr(cur_addr), .durable(durable_q), .mark(epoch_chg),
    .rewind(iter_rewind), .step(iter_next), .valid(iter_valid), .addr(iter_addr)
  );

  always_ff @(posedge clk) begin
    if (rst) epoch_q <= epoch_in;
    else     epoch_q <= epoch_in;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      durable_q <= '0;
      cur_addr  <= '0;
      cur_epoch <= '0;
      cur_data  <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (!q_empty) begin
          cur_addr  <= q_out[ENT_W-1:EPOCH_W];
          cur_epoch <= q_out[EPOCH_W-1:0];
          state     <= ST_READ;
        end
        ST_READ: if (mem_rd_valid) begin
          cur_data <= mem_rd_data;
          state    <= ST_WRITE;
        end
        ST_WRITE: if (log_wr_ack) begin
          durable_q <= durable_q + 1'b1;
          state     <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign mem_rd_req   = (state == ST_READ);
  assign mem_rd_addr  = cur_addr;
  assign log_wr_req   = (state == ST_WRITE);
  assign log_wr_slot  = durable_q[SLOT_W-1:0];
  assign log_wr_addr  = cur_addr;
  assign log_wr_data  = cur_data;
  assign log_wr_epoch = cur_epoch;
  assign durable_off  = durable_q;
endmodule

// File: rtl/ul_checker.sv
module ul_checker #(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 32,
  parameter int EPOCH_W = 8,
  parameter int OFF_W   = 16,
  parameter int QDEPTH  = 4,
  localparam int QCNT_W = $clog2(QDEPTH + 1)
) (
  input logic               clk,
  input logic               rst,
  input logic               req_grant,
  input logic [EPOCH_W-1:0] epoch_in,
  input logic [EPOCH_W-1:0] epoch_q,
  input logic [QCNT_W-1:0]  q_count,
  input logic               set_hit,
  input logic               mem_rd_req,
  input logic [ADDR_W-1:0]  mem_rd_addr,
  input logic               mem_rd_valid,
  input logic               log_wr_req,
  input logic [ADDR_W-1:0]  log_wr_addr,
  input logic [DATA_W-1:0]  log_wr_data,
  input logic               log_wr_ack,
  input logic [OFF_W-1:0]   durable_off
);
  assert_full_only_hits_R3: assert property (@(posedge clk) disable iff (rst)
    (req_grant && q_count == QCNT_W'(QDEPTH)) |-> set_hit);

  assert_no_grant_on_epoch_R7: assert property (@(posedge clk) disable iff (rst)
    (epoch_in != epoch_q) |-> !req_grant);

  assert_durable_step_R5: assert property (@(posedge clk) disable iff (rst)
    (durable_off != $past(durable_off)) |->
      (durable_off == OFF_W'($past(durable_off) + 1'b1)) && $past(log_wr_req && log_wr_ack));

  assert_log_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (log_wr_req && !log_wr_ack) |=>
      (log_wr_req && $stable(log_wr_addr) && $stable(log_wr_data)));

  assert_read_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (mem_rd_req && !mem_rd_valid) |=> (mem_rd_req && $stable(mem_rd_addr)));

  assert_single_op_R11: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd_req && log_wr_req));
endmodule

bind undo_logger ul_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .EPOCH_W(EPOCH_W), .OFF_W(OFF_W), .QDEPTH(QDEPTH)
) u_chk (
  .clk(clk), .rst(rst), .req_grant(req_grant), .epoch_in(epoch_in), .epoch_q(epoch_q),
  .q_count(q_count), .set_hit(set_hit), .mem_rd_req(mem_rd_req),
  .mem_rd_addr(mem_rd_addr), .mem_rd_valid(mem_rd_valid), .log_wr_req(log_wr_req),
  .log_wr_addr(log_wr_addr), .log_wr_data(log_wr_data), .log_wr_ack(log_wr_ack),
  .durable_off(durable_off)
);

// File: tb/undo_logger_test.sv
module undo_logger_test;
  logic        clk = 0, rst = 1;
  logic        req_valid = 0;
  logic [15:0] req_addr = '0;
  logic        req_grant;
  logic [7:0]  epoch_in = 8'd1;
  logic        mem_rd_req, mem_rd_valid = 0;
  logic [15:0] mem_rd_addr;
  logic [31:0] mem_rd_data = '0;
  logic        log_wr_req, log_wr_ack = 0;
  logic [3:0]  log_wr_slot;
  logic [15:0] log_wr_addr, iter_addr;
  logic [31:0] log_wr_data;
  logic [7:0]  log_wr_epoch;
  logic [15:0] durable_off;
  logic        iter_rewind = 0, iter_next = 0, iter_valid;

  int checks = 0, errors = 0, n_log = 0, rd_cnt = 0, wr_cnt = 0;
  bit mem_stall = 0, log_stall = 0, overlap = 0, done = 0;
  logic [15:0] lg_addr [32];
  logic [31:0] lg_data [32];
  logic [7:0]  lg_epoch [32];
  logic [3:0]  lg_slot [32];

  // vector: {new line expected, address}
  localparam logic [16:0] VEC [7] = '{
    {1'b1, 16'h0100}, {1'b1, 16'h0200}, {1'b0, 16'h0100}, {1'b1, 16'h0300},
    {1'b0, 16'h0200}, {1'b0, 16'h0300}, {1'b1, 16'h0400}
  };

  always #2.5 clk = ~clk;

  undo_logger uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr), .req_grant(req_grant),
    .epoch_in(epoch_in), .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
    .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data), .log_wr_req(log_wr_req),
    .log_wr_slot(log_wr_slot), .log_wr_addr(log_wr_addr), .log_wr_data(log_wr_data),
    .log_wr_epoch(log_wr_epoch), .log_wr_ack(log_wr_ack), .durable_off(durable_off),
    .iter_rewind(iter_rewind), .iter_next(iter_next), .iter_valid(iter_valid),
    .iter_addr(iter_addr)
  );

  function automatic logic [31:0] old_line(input logic [15:0] a);
    return {a, ~a};
  endfunction

  always @(negedge clk) begin
    mem_rd_valid = 0;
    log_wr_ack   = 0;
    if (mem_rd_req && log_wr_req) overlap = 1;
    if (mem_rd_req && !mem_stall) begin
      rd_cnt++;
      if (rd_cnt >= 2) begin
        mem_rd_valid = 1;
        mem_rd_data  = old_line(mem_rd_addr);
        rd_cnt = 0;
      end
    end
    if (log_wr_req && !log_stall) begin
      wr_cnt++;
      if (wr_cnt >= 2) begin
        log_wr_ack = 1;
        wr_cnt = 0;
        if (n_log < 32) begin
          lg_addr[n_log]  = log_wr_addr;
          lg_data[n_log]  = log_wr_data;
          lg_epoch[n_log] = log_wr_epoch;
          lg_slot[n_log]  = log_wr_slot;
        end
        n_log++;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_req(input logic [15:0] a, output logic g);
    @(negedge clk);
    req_valid = 1;
    req_addr  = a;
    #1 g = req_grant;
    @(posedge clk);
    #1 req_valid = 0;
  endtask

  task automatic wait_durable(input logic [15:0] target);
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (durable_off == target) break;
    end
  endtask

  task automatic check_entry(input int idx, input logic [15:0] a, input logic [7:0] ep);
    chk(lg_addr[idx] == a, "R4 addr", lg_addr[idx], a);
    chk(lg_data[idx] == old_line(a), "R4 data", lg_data[idx], old_line(a));
    chk(lg_epoch[idx] == ep, "R4 epoch", lg_epoch[idx], ep);
  endtask

  task automatic replay(input logic [15:0] exp [], input int n);
    @(negedge clk);
    iter_rewind = 1;
    @(posedge clk);
    #1 iter_rewind = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      chk(iter_valid && iter_addr == exp[k], "R9 replay", iter_addr, exp[k]);
      iter_next = 1;
      @(posedge clk);
      #1 iter_next = 0;
    end
    @(negedge clk);
    chk(!iter_valid, "R9 end", iter_valid, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic g;
    logic [15:0] prev;
    logic gk [6];
    logic [15:0] e4 [] = '{16'h0100, 16'h0200, 16'h0300, 16'h0400};
    logic [15:0] e1 [] = '{16'h0100};

    repeat (4) @(posedge clk);
    #1 rst = 0;
    @(negedge clk);
    // R10 reset state
    chk(durable_off == 0, "R10 durable", durable_off, 0);
    chk(!req_grant, "R10 grant", req_grant, 0);
    chk(!mem_rd_req && !log_wr_req, "R10 mem idle", {mem_rd_req, log_wr_req}, 0);
    chk(!iter_valid, "R10 iter", iter_valid, 0);

    // table walk: R1, R2, R4, R6
    for (int i = 0; i < 7; i++) begin
      prev = durable_off;
      do_req(VEC[i][15:0], g);
      chk(g == 1, "R1 grant", g, 1);
      wait_durable(prev + 16'(VEC[i][16]));
      repeat (12) @(negedge clk);
      chk(durable_off == prev + 16'(VEC[i][16]), "R2 record count", durable_off, prev + 16'(VEC[i][16]));
      if (VEC[i][16]) begin
        check_entry(int'(prev), VEC[i][15:0], 8'd1);
        chk(lg_slot[prev] == prev[3:0], "R6 slot", lg_slot[prev], prev[3:0]);
      end
    end

    replay(e4, 4);

    // R7 epoch change
    @(negedge clk);
    epoch_in = 8'd2;
    req_valid = 1;
    req_addr = 16'h0100;
    #1 chk(!req_grant, "R7 grant on change", req_grant, 0);
    @(posedge clk);
    #1 req_valid = 0;
    do_req(16'h0100, g);
    chk(g == 1, "R7 regrant", g, 1);
    wait_durable(16'd5);
    chk(durable_off == 5, "R7 relogged", durable_off, 5);
    check_entry(4, 16'h0100, 8'd2);
    replay(e1, 1);

    // R5 durable waits for ack
    log_stall = 1;
    do_req(16'h0500, g);
    repeat (10) @(negedge clk);
    chk(durable_off == 5, "R5 stalled", durable_off, 5);
    log_stall = 0;
    wait_durable(16'd6);
    chk(durable_off == 6, "R5 after ack", durable_off, 6);

    // R3 queue full
    mem_stall = 1;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      req_valid = 1;
      req_addr = 16'h0601 + 16'(k);
      #1 gk[k] = req_grant;
    end
    @(negedge clk);
    req_addr = 16'h0601;
    #1 chk(req_grant == 1, "R3 repeat when full", req_grant, 1);
    @(posedge clk);
    #1 req_valid = 0;
    for (int k = 0; k < 5; k++) chk(gk[k] == 1, "R3 accepted", gk[k], 1);
    chk(gk[5] == 0, "R3 withheld", gk[5], 0);
    mem_stall = 0;
    wait_durable(16'd11);
    chk(durable_off == 11, "R3 drained", durable_off, 11);
    for (int k = 0; k < 5; k++)
      chk(lg_addr[6+k] == 16'h0601 + 16'(k), "R5 order", lg_addr[6+k], 16'h0601 + 16'(k));

    // R8 set full
    do_req(16'h0700, g);
    chk(g == 1, "R8 eighth line", g, 1);
    wait_durable(16'd12);
    do_req(16'h0701, g);
    chk(g == 0, "R8 withheld", g, 0);
    do_req(16'h0700, g);
    chk(g == 1, "R8 repeat", g, 1);
    repeat (12) @(negedge clk);
    chk(durable_off == 12, "R8 no record", durable_off, 12);

    // R6 wrap in epoch 3
    @(negedge clk);
    epoch_in = 8'd3;
    @(posedge clk);
    for (int k = 0; k < 6; k++) begin
      do_req(16'h0800 + 16'(k), g);
      wait_durable(16'd13 + 16'(k));
    end
    chk(durable_off == 18, "R6 total", durable_off, 18);
    for (int i = 0; i < 18; i++)
      chk(lg_slot[i] == 4'(i), "R6 wrap slot", lg_slot[i], 4'(i));
    check_entry(17, 16'h0805, 8'd3);
    chk(!overlap, "R11 one op", overlap, 0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule